// File: doc/BRIEF.md
# Master-Clock Raster Timing Generator

This block counts master clocks to give the raster position for a console video and CPU subsystem. It produces a horizontal position in master clocks and a vertical line number. It also gives a field flag, horizontal and vertical blank flags, and a refresh-busy window. During that window every CPU-side bus access, DMA included, has to wait for the DRAM refresh.

Most lines are 1364 clocks long. In the 60 Hz region with interlace off, one line of every odd field loses four clocks. The number of lines in a field depends on the region and, when interlace is on, on the field. The refresh window starts at a fixed position with the early chip revision. With the later revision its start moves between two positions from line to line, and it holds its position across the short line.

The region, interlace and revision inputs take effect only at a field boundary. The overscan input takes effect at once. The vertical sizes are parameters, and the bench uses them to shorten simulation. The horizontal timing is fixed.

Top module: `raster_timer`

## Requirements
- R1: While `rst` is high on a clock edge, the block sets `hpos`=0, `vpos`=0, `field_odd`=0 and `refresh_busy`=0, and it samples `cfg_pal`, `cfg_interlace` and `cfg_rev1`.
- R2: A normal line lasts 1364 clocks. `hpos` steps by one each clock from 0 to 1363 and then returns to 0, and at that point `vpos` advances.
- R3: A line is short when `cfg_pal`=0 and `cfg_interlace`=0 as sampled, `field_odd`=1 and `vpos`=SHORT_LINE (default 240). A short line lasts 1360 clocks, with `hpos` ending at 1359.
- R4: A field has NTSC_LINES lines (default 262) when `cfg_pal`=0 and PAL_LINES lines (default 312) when `cfg_pal`=1. It has one extra line when interlace is on and `field_odd`=0.
- R5: `field_odd` toggles when the last line of a field wraps. `cfg_pal`, `cfg_interlace` and `cfg_rev1` are sampled only on that clock, so any change to them in the middle of a field has no effect until the next field.
- R6: `hblank` is 1 exactly when `hpos` is 3 or less, or 1096 or more. This gives 272 blank clocks on a normal line and 268 on the short line.
- R7: `vblank` is 1 exactly when `vpos` is at least VBL_LINE (default 225), or at least VBL_LINE_OS (default 240) while `cfg_overscan`=1. `cfg_overscan` acts without delay.
- R8: `refresh_busy` is a registered output. It is high for exactly 40 consecutive clocks on each line, from `hpos`=start to start+39, and it never crosses a line boundary.
- R9: With `cfg_rev1`=1 as sampled, the refresh start is 530 on every line.
- R10: With `cfg_rev1`=0, the refresh start is 538 on the first line after reset. It then moves to the other value of 538 and 534 after each line, except that a short line leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pal | input | 1 | 1 = 50 Hz region line count, 0 = 60 Hz region |
| cfg_interlace | input | 1 | Interlace enable |
| cfg_overscan | input | 1 | Moves the start of vblank to the later line |
| cfg_rev1 | input | 1 | 1 = early revision with a fixed refresh start |
| hpos | output | 11 | Horizontal position in master clocks |
| vpos | output | 9 | Line number within the field |
| field_odd | output | 1 | Current field, 1 = odd |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| refresh_busy | output | 1 | DRAM refresh window, stalls the CPU side |

## Verification
A wrong horizontal count shows up first in `hblank` and `refresh_busy`, which go off phase within the same line. The next line boundary then also moves `vpos`. A refresh phase that fails to move, or that moves on the short line, shifts the busy window by four clocks on the very next line. A miscounted field length or an unsampled configuration change shows as a wrong `field_odd` or a short line missing at the next field boundary. The bench therefore checks every output on every clock against its own model, so each fault is reported in the cycle where it first appears.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int NTSC_LINES  = 262,
  parameter int PAL_LINES   = 312,
  parameter int SHORT_LINE  = 240,
  parameter int VBL_LINE    = 225,
  parameter int VBL_LINE_OS = 240
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_pal,
  input  logic        cfg_interlace,
  input  logic        cfg_overscan,
  input  logic        cfg_rev1,
  output logic [10:0] hpos,
  output logic [8:0]  vpos,
  output logic        field_odd,
  output logic        hblank,
  output logic        vblank,
  output logic        refresh_busy
);
  localparam logic [10:0] H_LAST       = 11'd1363;
  localparam logic [10:0] H_LAST_SHORT = 11'd1359;
  localparam logic [10:0] HB_END       = 11'd3;
  localparam logic [10:0] HB_START     = 11'd1096;
  localparam logic [10:0] REF_REV1     = 11'd530;
  localparam logic [10:0] REF_A        = 11'd538;
  localparam logic [10:0] REF_B        = 11'd534;
  localparam logic [10:0] REF_LEN      = 11'd40;
  localparam logic [8:0]  NTSC_LAST    = 9'(NTSC_LINES - 1);
  localparam logic [8:0]  PAL_LAST     = 9'(PAL_LINES - 1);

  logic pal_q, il_q, rev_q, alt_q;

  logic        short_line, line_end, field_end, alt_nxt;
  logic [8:0]  v_last;
  logic [10:0] h_nxt, ref_start;

  assign short_line = !pal_q && !il_q && field_odd && (vpos == 9'(SHORT_LINE));
  assign line_end   = hpos == (short_line ? H_LAST_SHORT : H_LAST);
  assign v_last     = (pal_q ? PAL_LAST : NTSC_LAST) + 9'(il_q && !field_odd);
  assign field_end  = line_end && (vpos == v_last);
  assign h_nxt      = line_end ? 11'd0 : hpos + 11'd1;
  assign alt_nxt    = (line_end && !short_line) ? !alt_q : alt_q;
  assign ref_start  = rev_q ? REF_REV1 : (alt_nxt ? REF_B : REF_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos         <= '0;
      vpos         <= '0;
      field_odd    <= 1'b0;
      alt_q        <= 1'b0;
      refresh_busy <= 1'b0;
      pal_q        <= cfg_pal;
      il_q         <= cfg_interlace;
      rev_q        <= cfg_rev1;
    end else begin
      hpos         <= h_nxt;
      alt_q        <= alt_nxt;
      refresh_busy <= (h_nxt >= ref_start) && (h_nxt < ref_start + REF_LEN);
      if (line_end) vpos <= field_end ? 9'd0 : vpos + 9'd1;
      if (field_end) begin
        field_odd <= !field_odd;
        pal_q     <= cfg_pal;
        il_q      <= cfg_interlace;
        rev_q     <= cfg_rev1;
      end
    end
  end

  assign hblank = (hpos <= HB_END) || (hpos >= HB_START);
  assign vblank = vpos >= (cfg_overscan ? 9'(VBL_LINE_OS) : 9'(VBL_LINE));
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_overscan,
  input logic [10:0] hpos,
  input logic [8:0]  vpos,
  input logic        field_odd,
  input logic        hblank,
  input logic        vblank,
  input logic        refresh_busy
);
  AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
    hpos == 11'd1363 |=> hpos == 11'd0);  // R2
  AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
    (hpos != 11'd1363 && hpos != 11'd1359) |=> hpos == $past(hpos) + 11'd1);  // R2
  AST_H_RANGE: assert property (@(posedge clk) disable iff (rst)
    hpos <= 11'd1363);  // R3
  AST_FIELD_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_odd) |-> (hpos == 11'd0 && vpos == 9'd0));  // R5
  AST_HBLANK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(hblank) |-> hpos == 11'd1096);  // R6
  AST_VBLANK_FALL: assert property (@(posedge clk) disable iff (rst)
    ($fell(vblank) && $stable(cfg_overscan)) |-> vpos == 9'd0);  // R7
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_busy) |-> (hpos == 11'd530 || hpos == 11'd534 || hpos == 11'd538));  // R8
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    refresh_busy |-> (hpos >= 11'd530 && hpos <= 11'd577));  // R8
endmodule

bind raster_timer raster_timer_chk u_chk (
  .clk(clk), .rst(rst), .cfg_overscan(cfg_overscan),
  .hpos(hpos), .vpos(vpos), .field_odd(field_odd),
  .hblank(hblank), .vblank(vblank), .refresh_busy(refresh_busy)
);

// File: tb/sim_raster_timer.sv
`timescale 1ns/1ps
module sim_raster_timer;
  localparam int NL = 12, PL = 14, SL = 9, VB = 7, VBO = 9;
  localparam int RUN = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_pal = 1'b0, cfg_interlace = 1'b0, cfg_overscan = 1'b0, cfg_rev1 = 1'b0;
  logic [10:0] hpos;
  logic [8:0]  vpos;
  logic field_odd, hblank, vblank, refresh_busy;

  raster_timer #(.NTSC_LINES(NL), .PAL_LINES(PL), .SHORT_LINE(SL),
                 .VBL_LINE(VB), .VBL_LINE_OS(VBO)) u0 (
    .clk(clk), .rst(rst), .cfg_pal(cfg_pal), .cfg_interlace(cfg_interlace),
    .cfg_overscan(cfg_overscan), .cfg_rev1(cfg_rev1), .hpos(hpos), .vpos(vpos),
    .field_odd(field_odd), .hblank(hblank), .vblank(vblank), .refresh_busy(refresh_busy));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, shorts = 0;
  int mh = 0, mv = 0;
  bit mf = 0, malt = 0, mpal = 0, mil = 0, mrev = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit is_short();
    return !mpal && !mil && mf && mv == SL;
  endfunction

  function automatic int ref_start();
    return mrev ? 530 : (malt ? 534 : 538);
  endfunction

  task automatic model_step();
    int last;
    if (rst) begin
      mh = 0; mv = 0; mf = 0; malt = 0;
      mpal = cfg_pal; mil = cfg_interlace; mrev = cfg_rev1;
      return;
    end
    last = is_short() ? 1359 : 1363;
    if (mh == last) begin
      if (is_short()) shorts++;
      else malt = !malt;
      mh = 0;
      if (mv == (mpal ? PL : NL) - 1 + int'(mil && !mf)) begin
        mv = 0; mf = !mf;
        mpal = cfg_pal; mil = cfg_interlace; mrev = cfg_rev1;
      end else mv++;
    end else mh++;
  endtask

  always @(negedge clk) if (!done) begin
    int s;
    // R1 covered while rst is high, R2 R3 R4 via position
    chk("R2/R3 hpos", int'(hpos), mh);
    chk("R4 vpos", int'(vpos), mv);
    chk("R5 field", int'(field_odd), int'(mf));
    chk("R6 hblank", int'(hblank), int'(mh <= 3 || mh >= 1096));
    chk("R7 vblank", int'(vblank), int'(mv >= (cfg_overscan ? VBO : VB)));
    s = ref_start();
    chk(mrev ? "R8 R9 busy" : "R8 R10 busy", int'(refresh_busy),
        int'(!rst && mh >= s && mh < s + 40 && cyc > 0));
    cyc++;
    if (cyc == 4) rst = 1'b0;
    if (cyc > 60000 && cyc < RUN) begin
      if ($urandom_range(2999) == 0) cfg_pal = $urandom_range(1);
      if ($urandom_range(2999) == 0) cfg_interlace = $urandom_range(1);
      if ($urandom_range(999) == 0) cfg_overscan = $urandom_range(1);
      if ($urandom_range(2999) == 0) cfg_rev1 = $urandom_range(1);
    end
    if (cyc == 20000) cfg_overscan = 1'b1;
    if (cyc == 30000) cfg_pal = 1'b1;
    if (cyc == 40000) cfg_pal = 1'b0;
    if (cyc == 110000) rst = 1'b1;
    if (cyc == 110003) rst = 1'b0;
    model_step();
    if (cyc >= RUN) begin
      done = 1;
      checks++;
      if (shorts == 0) begin
        fails++;
        $display("FAIL R3 short lines actual %0d expected >0", shorts);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    #(195000.0 * 5.0);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, RUN);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule